// File: doc/BRIEF.md
# Framed serial word transmitter

This block sends 16-bit two's-complement results from a converter over a synchronous serial port that carries its own clock. It divides the master clock by three to make the serial clock, which is high for one master cycle and low for two. It drives an active-low frame-sync output that marks each word, and it shifts the word out most significant bit first. The serial data and the serial clock each have a complementary output for differential signalling.

A producer presents a word on `word_in` and pulses `word_vld` for one master cycle. If the port is idle, the frame begins on the next falling edge of the serial clock. If a frame is already in progress, the word is held in a one-entry holding register and starts once the current frame is complete. The receiver samples data on the rising edge of the serial clock. A 400 kHz word rate from a 25.6 MHz master clock gives 64 master cycles per word. A frame with its guard gap needs at most 51 of them.

Top module: `fsw_tx`

## Requirements
- R1: `sclk` repeats every 3 master cycles: high for exactly 1 cycle, then low for 2. `sclk_n` is always the inverse of `sclk`.
- R2: `fs_n` falls only on a master edge where `sclk` also falls. After a `word_vld` pulse on an idle port, `fs_n` falls within 3 master cycles.
- R3: While `fs_n` is low, `sclk` rises exactly 16 times. `fs_n` then returns high on a falling edge of `sclk`.
- R4: Bit 15 is presented first and bit 0 last, one bit per rising edge of `sclk`. `sdo` changes only on master edges where `sclk` falls. `sdo_n` is always the inverse of `sdo`.
- R5: The 16-bit pattern is sent unaltered, including the extreme two's-complement values 16'h8000 and 16'h7FFF.
- R6: While `fs_n` is high, `sdo` is 0.
- R7: A word strobed while a frame is in progress is sent in the next frame, after the current word.
- R8: If a second word is strobed while one is already waiting, the newer word replaces the waiting one. The replaced word is never sent.
- R9: Between two frames, `fs_n` stays high for at least one full serial-clock period (3 master cycles).
- R10: Synchronous active-high `rst` forces `sclk`=0, `fs_n`=1 and `sdo`=0, and drops any frame in progress and any waiting word. No frame follows reset unless a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 16 | Word to transmit, two's complement |
| word_vld | input | 1 | One-cycle strobe: `word_in` is valid |
| sdo | output | 1 | Serial data, MSB first |
| sdo_n | output | 1 | Inverse of `sdo` |
| sclk | output | 1 | Serial clock, master clock / 3 |
| sclk_n | output | 1 | Inverse of `sclk` |
| fs_n | output | 1 | Frame sync, low for the 16 bits of a word |

## Verification
The bench first sends single words with sparse and dense bit patterns: the two signed extremes, all zeros, all ones, alternating bits and a lone LSB. These show whether bit order, bit count and bit values each survive the shift path, since a swap, a dropped bit or a stuck bit changes at least one of them. A word strobed in the middle of a frame separates a design that holds the word from one that drops it or cuts into the running frame. Three strobes inside one frame show whether the waiting slot keeps the newest word. A reset with a word waiting shows whether reset clears the waiting slot as well as the shifter. A bus monitor checks every cycle for clock duty, the edges on which data and frame sync change, the complement outputs, the idle level and the gap between frames.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    localparam int unsigned FSW_WORD_W   = 16;
    localparam int unsigned FSW_DIV      = 3;
    localparam int unsigned FSW_HIGH_CYC = 1;
endpackage

// File: rtl/fsw_clkdiv.sv
module fsw_clkdiv #(
    parameter int unsigned DIV      = 3,
    parameter int unsigned HIGH_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic fall_tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST  = PW'(DIV - 1);
    localparam logic [PW-1:0] HI_END = PW'(HIGH_CYC - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          sclk;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + 1'b1;
        st_d.sclk  = (st_d.phase <= HI_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= LAST;
            st_q.sclk  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk      = st_q.sclk;
    assign fall_tick = (st_q.phase == HI_END);
endmodule

// File: rtl/fsw_hold.sv
module fsw_hold #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic         avail,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            // the shifter takes the held word if there is one, else din directly
            st_d.full = vld && st_q.full;
        end else begin
            st_d.full = st_q.full || vld;
        end
        if (vld) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail = st_q.full || vld;
    assign word  = st_q.full ? st_q.data : din;
endmodule

// File: rtl/fsw_shift.sv
module fsw_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         avail,
    input  logic [W-1:0] word,
    output logic         take,
    output logic         sdo,
    output logic         fs_n
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sreg;
        logic          sdo;
        logic          fs_n;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (tick) begin
            if (st_q.busy) begin
                if (st_q.cnt == LAST_BIT) begin
                    st_d.busy = 1'b0;
                    st_d.fs_n = 1'b1;
                    st_d.sdo  = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt  = st_q.cnt + 1'b1;
                    st_d.sdo  = st_q.sreg[W-2];
                    st_d.sreg = {st_q.sreg[W-2:0], 1'b0};
                end
            end else if (avail) begin
                take      = 1'b1;
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.sreg = word;
                st_d.sdo  = word[W-1];
                st_d.fs_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.fs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo  = st_q.sdo;
    assign fs_n = st_q.fs_n;
endmodule

// File: rtl/fsw_tx.sv
module fsw_tx
    import fsw_pkg::*;
#(
    parameter int unsigned WORD_W   = FSW_WORD_W,
    parameter int unsigned DIV      = FSW_DIV,
    parameter int unsigned HIGH_CYC = FSW_HIGH_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_vld,
    output logic              sdo,
    output logic              sdo_n,
    output logic              sclk,
    output logic              sclk_n,
    output logic              fs_n
);
    logic              tick;
    logic              take;
    logic              avail;
    logic [WORD_W-1:0] word_sel;

    fsw_clkdiv #(.DIV(DIV), .HIGH_CYC(HIGH_CYC)) u_div (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .fall_tick (tick)
    );

    fsw_hold #(.W(WORD_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .vld   (word_vld),
        .din   (word_in),
        .take  (take),
        .avail (avail),
        .word  (word_sel)
    );

    fsw_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .avail (avail),
        .word  (word_sel),
        .take  (take),
        .sdo   (sdo),
        .fs_n  (fs_n)
    );

    assign sdo_n  = ~sdo;
    assign sclk_n = ~sclk;
endmodule

// File: rtl/fsw_tx_chk.sv
module fsw_tx_chk #(
    parameter int unsigned W = 16
) (
    input logic clk,
    input logic rst,
    input logic sdo,
    input logic sdo_n,
    input logic sclk,
    input logic sclk_n,
    input logic fs_n
);
    localparam int unsigned CW = $clog2(W) + 1;

    logic          prev_sclk;
    logic          prev_fs;
    logic [CW-1:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sclk <= 1'b0;
            prev_fs   <= 1'b1;
            rises     <= '0;
        end else begin
            prev_sclk <= sclk;
            prev_fs   <= fs_n;
            if (prev_fs && !fs_n) begin
                rises <= '0;
            end else if (!fs_n && sclk && !prev_sclk) begin
                rises <= rises + 1'b1;
            end
        end
    end

    AST_SCLK_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |=> !sclk); // R1
    AST_SCLK_TWO_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |=> !sclk); // R1
    AST_FS_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(fs_n) |-> $fell(sclk)); // R2
    AST_FS_END_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_n) |-> $fell(sclk)); // R3
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_n) |-> (rises == CW'(W))); // R3
    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdo)); // R4
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        fs_n |-> !sdo); // R6
    AST_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_n) |=> fs_n); // R9
endmodule

bind fsw_tx fsw_tx_chk #(.W(WORD_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sdo    (sdo),
    .sdo_n  (sdo_n),
    .sclk   (sclk),
    .sclk_n (sclk_n),
    .fs_n   (fs_n)
);

// File: tb/test_fsw_tx.sv
module test_fsw_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF,
        16'hA5A5, 16'h5A5A, 16'h0001, 16'h1234
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] word_in = '0;
    logic        word_vld = 1'b0;
    logic        sdo, sdo_n, sclk, sclk_n, fs_n;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsw_tx i_fsw_tx (
        .clk(clk), .rst(rst), .word_in(word_in), .word_vld(word_vld),
        .sdo(sdo), .sdo_n(sdo_n), .sclk(sclk), .sclk_n(sclk_n), .fs_n(fs_n)
    );

    // bus monitor
    logic [15:0] rx_word [64];
    int          rx_len  [64];
    int          rx_cnt = 0;
    logic [15:0] cap;
    int          bits, hi_run, lo_run, fs_hi_run;
    logic        seen_rise, prev_sclk, prev_fs, prev_sdo;
    logic        bad_clk = 0, bad_compl = 0, bad_idle = 0, bad_dchg = 0;
    logic        bad_fs = 0, bad_gap = 0;
    bit          first_frame = 1;

    always @(negedge clk) begin
        if (sdo_n !== ~sdo || sclk_n !== ~sclk) bad_compl <= 1;
        if (rst) begin
            cap = '0; bits = 0; hi_run = 0; lo_run = 0; fs_hi_run = 99;
            seen_rise = 0; prev_sclk = sclk; prev_fs = 1; prev_sdo = sdo;
            first_frame = 1;
        end else begin
            if (sclk && !prev_sclk) begin
                if (seen_rise && lo_run != 2) bad_clk <= 1;
                seen_rise = 1; hi_run = 1; lo_run = 0;
            end else if (sclk) begin
                hi_run++;
                if (hi_run > 1) bad_clk <= 1;
            end else begin
                lo_run++;
            end
            if (fs_n && sdo) bad_idle <= 1;
            if (sdo != prev_sdo && !(!sclk && prev_sclk)) bad_dchg <= 1;
            if (fs_n != prev_fs && !(!sclk && prev_sclk)) bad_fs <= 1;
            if (prev_fs && !fs_n) begin
                if (!first_frame && fs_hi_run < 3) bad_gap <= 1;
                first_frame = 0; bits = 0; cap = '0;
            end
            if (fs_n) fs_hi_run++; else fs_hi_run = 0;
            if (sclk && !prev_sclk && !fs_n) begin
                cap = {cap[14:0], sdo}; bits++;
            end
            if (!prev_fs && fs_n) begin
                rx_word[rx_cnt] = cap; rx_len[rx_cnt] = bits; rx_cnt++;
            end
            prev_sclk = sclk; prev_fs = fs_n; prev_sdo = sdo;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk); #1;
        word_in = w; word_vld = 1'b1;
        @(negedge clk); #1;
        word_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_rx(input int target);
        for (int k = 0; k < 400 && rx_cnt < target; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        int lat;
        idle(3);
        // R10: outputs under reset
        check(sclk == 0 && fs_n == 1 && sdo == 0, "R10 reset", {sclk, fs_n, sdo}, 3'b010);
        check(sclk_n == 1 && sdo_n == 1, "R10 reset compl", {sclk_n, sdo_n}, 2'b11);
        @(negedge clk); #1; rst = 1'b0;
        idle(20);
        // R6: idle port stays quiet
        check(fs_n == 1 && sdo == 0 && rx_cnt == 0, "R6 idle", {fs_n, sdo}, 2'b10);

        // R2: latency from strobe to frame start
        @(negedge clk); #1;
        word_in = 16'hC3C3; word_vld = 1'b1;
        lat = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); #1;
            word_vld = 1'b0;
            if (fs_n == 0) begin lat = k; break; end
        end
        check(lat >= 1 && lat <= 3, "R2 start latency", lat, 3);
        wait_rx(1);
        check(rx_cnt == 1 && rx_word[0] == 16'hC3C3, "R4 first word", rx_word[0], 16'hC3C3);

        // table walk: R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            base = rx_cnt;
            idle(i * 5);
            send(VEC[i]);
            wait_rx(base + 1);
            check(rx_cnt == base + 1 && rx_word[base] == VEC[i], "R5 word value",
                  rx_word[base], VEC[i]);
            check(rx_len[base] == 16, "R3 bit count", rx_len[base], 16);
        end

        // R7: word strobed mid-frame follows the current one
        base = rx_cnt;
        idle(10);
        send(16'h1111);
        idle(12);
        send(16'h2222);
        wait_rx(base + 2);
        check(rx_cnt == base + 2 && rx_word[base] == 16'h1111, "R7 first", rx_word[base], 16'h1111);
        check(rx_word[base+1] == 16'h2222, "R7 held word", rx_word[base+1], 16'h2222);

        // R8: newest waiting word replaces older one
        base = rx_cnt;
        idle(10);
        send(16'hAAAA);
        idle(10);
        send(16'hBBBB);
        idle(3);
        send(16'hCCCC);
        wait_rx(base + 2);
        idle(150);
        check(rx_cnt == base + 2, "R8 frame count", rx_cnt - base, 2);
        check(rx_word[base+1] == 16'hCCCC, "R8 newest kept", rx_word[base+1], 16'hCCCC);

        // R10: reset mid-frame with a word waiting
        base = rx_cnt;
        idle(10);
        send(16'h0F0F);
        idle(10);
        send(16'hF0F0);
        idle(4);
        @(negedge clk); #1; rst = 1'b1;
        idle(3);
        check(fs_n == 1 && sdo == 0 && sclk == 0, "R10 mid-frame reset", {sclk, fs_n, sdo}, 3'b010);
        @(negedge clk); #1; rst = 1'b0;
        idle(200);
        check(rx_cnt == base && fs_n == 1, "R10 waiting word dropped", rx_cnt - base, 0);
        send(16'h4321);
        wait_rx(base + 1);
        check(rx_word[base] == 16'h4321, "R10 after reset", rx_word[base], 16'h4321);
        idle(20);

        // continuous monitor results
        check(!bad_clk, "R1 sclk duty", bad_clk, 0);
        check(!bad_compl, "R1 R4 complements", bad_compl, 0);
        check(!bad_dchg, "R4 data edge", bad_dchg, 0);
        check(!bad_fs, "R2 R3 frame edge", bad_fs, 0);
        check(!bad_idle, "R6 idle data", bad_idle, 0);
        check(!bad_gap, "R9 gap", bad_gap, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule